// File: doc/BRIEF.md
# Fifteen-Cent Coin Vending Controller

This block is the decision logic for a vending slot that takes nickels (5 cents) and dimes (10 cents) and frees one item once the paid credit reaches 15 cents. A coin sensor upstream pulses `nickel_in` or `dime_in` for a single clock cycle per coin. The block keeps the running credit in one of four named states, and it drives `release_o` to the release mechanism. Credit paid above 15 cents is absorbed. No change is returned.

The states are `CR_ZERO` (0 cents), `CR_FIVE` (5 cents), `CR_TEN` (10 cents) and `CR_FULL` (15 cents, paid). The transitions are as follows. A nickel steps ZERO→FIVE, FIVE→TEN and TEN→FULL. A dime steps ZERO→TEN, FIVE→FULL and TEN→FULL. With no coin, every state loops to itself. FULL loops to itself whatever the coin inputs, until reset. Reset sends every state to ZERO.

The parameter `MEALY_OUT` picks the release output form. With 0 (Moore form), the output is decoded from the state alone. With 1 (Mealy form), the output is also raised combinationally on the arc that completes payment. The parameter `ONE_HOT` picks how the state register holds the state. With 0 it uses two binary flip-flops: ZERO=00, FIVE=01, TEN=10, FULL=11. With 1 it uses four flip-flops, one per state. Port behaviour is the same for both encodings.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high `rst` at a clock edge puts the machine in CR_ZERO. After that edge, with no coin, `release_o` is 0, whatever state the machine was in before.
- R2: A nickel pulse (`nickel_in`=1, `dime_in`=0) at an edge moves CR_ZERO→CR_FIVE, CR_FIVE→CR_TEN and CR_TEN→CR_FULL.
- R3: A dime pulse (`dime_in`=1, `nickel_in`=0) moves CR_ZERO→CR_TEN, CR_FIVE→CR_FULL and CR_TEN→CR_FULL. Any amount above 15 cents is dropped.
- R4: With both strobes low, the state does not change.
- R5: Once in CR_FULL, the machine stays there under any coin input until reset, and `release_o` stays 1.
- R6: In Moore form (`MEALY_OUT`=0), `release_o` is 1 exactly while the state is CR_FULL. It therefore first rises in the cycle after the clock edge that takes the completing coin.
- R7: In Mealy form (`MEALY_OUT`=1), `release_o` is also 1 in the same cycle as a completing coin. This covers a dime in CR_FIVE and either coin in CR_TEN. In any other non-FULL cycle it is 0.
- R8: When both strobes are high in one cycle, the machine treats them as a single dime.
- R9: With `ONE_HOT`=1, exactly one of the four state flip-flops is set at every edge after reset, and the port behaviour matches the binary encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to CR_ZERO |
| nickel_in | input | 1 | One-cycle pulse per 5-cent coin |
| dime_in | input | 1 | One-cycle pulse per 10-cent coin |
| release_o | output | 1 | High to free the item |

## Verification
The credit is not visible at the ports, so the hardest cases to reach are the paths into CR_FULL from each lower state, and the stickiness of FULL under further coins. The bench sweeps every sequence of four coin slots, each drawn from none, nickel, dime or both. It keeps an arithmetic credit model and compares `release_o` every cycle for a Moore/binary instance and a Mealy/one-hot instance. Each sequence starts with a reset, often from FULL, so that the reset path is exercised from a paid state.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int NUM_STATES = 4;
    localparam int ENC_BITS   = $clog2(NUM_STATES);

    typedef enum logic [ENC_BITS-1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_FULL = 2'b11
    } credit_e;
endpackage

// File: rtl/vend_next.sv
module vend_next
    import vend_pkg::*;
(
    input  credit_e cur,
    input  logic    nickel,
    input  logic    dime,
    output credit_e nxt
);
    logic dime_eff;
    logic nick_eff;

    // Both strobes together count as one dime (R8).
    assign dime_eff = dime;
    assign nick_eff = nickel & ~dime;

    always_comb begin
        nxt = cur;
        unique case (cur)
            CR_ZERO: begin
                if (dime_eff)      nxt = CR_TEN;
                else if (nick_eff) nxt = CR_FIVE;
            end
            CR_FIVE: begin
                if (dime_eff)      nxt = CR_FULL;
                else if (nick_eff) nxt = CR_TEN;
            end
            CR_TEN: begin
                if (dime_eff | nick_eff) nxt = CR_FULL;
            end
            CR_FULL: nxt = CR_FULL;
            default: nxt = CR_ZERO;
        endcase
    end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
    import vend_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  credit_e d,
    output credit_e q
);
    generate
        if (ONE_HOT) begin : g_onehot
            logic [NUM_STATES-1:0] hot_q;
            logic [NUM_STATES-1:0] hot_d;

            always_comb begin
                hot_d = '0;
                hot_d[d] = 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) hot_q <= NUM_STATES'(1);
                else     hot_q <= hot_d;
            end

            always_comb begin
                q = CR_ZERO;
                unique case (1'b1)
                    hot_q[0]: q = CR_ZERO;
                    hot_q[1]: q = CR_FIVE;
                    hot_q[2]: q = CR_TEN;
                    hot_q[3]: q = CR_FULL;
                    default:  q = CR_ZERO;
                endcase
            end

            p_single_hot_r9: assert property (@(posedge clk) disable iff (rst)
                $countones(hot_q) == 1)
                else $error("one-hot state register lost its single bit");
        end else begin : g_binary
            logic [ENC_BITS-1:0] bin_q;

            always_ff @(posedge clk) begin
                if (rst) bin_q <= CR_ZERO;
                else     bin_q <= d;
            end

            assign q = credit_e'(bin_q);
        end
    endgenerate
endmodule

// File: rtl/vend_release.sv
module vend_release
    import vend_pkg::*;
#(
    parameter bit MEALY_OUT = 1'b0
) (
    input  credit_e cur,
    input  logic    nickel,
    input  logic    dime,
    output logic    open_o
);
    generate
        if (MEALY_OUT) begin : g_mealy
            always_comb begin
                open_o = 1'b0;
                unique case (cur)
                    CR_ZERO: open_o = 1'b0;
                    CR_FIVE: open_o = dime;
                    CR_TEN:  open_o = nickel | dime;
                    CR_FULL: open_o = 1'b1;
                    default: open_o = 1'b0;
                endcase
            end
        end else begin : g_moore
            always_comb begin
                open_o = 1'b0;
                unique case (cur)
                    CR_FULL: open_o = 1'b1;
                    default: open_o = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter bit MEALY_OUT = 1'b0,
    parameter bit ONE_HOT   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel_in,
    input  logic dime_in,
    output logic release_o
);
    credit_e credit_q;
    credit_e credit_d;

    vend_next u_next (
        .cur    (credit_q),
        .nickel (nickel_in),
        .dime   (dime_in),
        .nxt    (credit_d)
    );

    vend_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
        .clk (clk),
        .rst (rst),
        .d   (credit_d),
        .q   (credit_q)
    );

    vend_release #(.MEALY_OUT(MEALY_OUT)) u_release (
        .cur    (credit_q),
        .nickel (nickel_in),
        .dime   (dime_in),
        .open_o (release_o)
    );

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> credit_q == CR_ZERO)
        else $error("reset did not clear credit");

    p_nickel_step_r2: assert property (@(posedge clk) disable iff (rst)
        (nickel_in && !dime_in && credit_q == CR_FIVE) |=> credit_q == CR_TEN)
        else $error("nickel from five did not reach ten");

    p_dime_five_r3: assert property (@(posedge clk) disable iff (rst)
        (dime_in && credit_q == CR_FIVE) |=> credit_q == CR_FULL)
        else $error("dime from five did not reach full");

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!nickel_in && !dime_in) |=> $stable(credit_q))
        else $error("credit moved without a coin");

    p_full_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        credit_q == CR_FULL |=> (credit_q == CR_FULL && release_o))
        else $error("paid state was left without reset");

    p_both_as_dime_r8: assert property (@(posedge clk) disable iff (rst)
        (nickel_in && dime_in && credit_q == CR_ZERO) |=> credit_q == CR_TEN)
        else $error("double strobe not taken as dime");

    generate
        if (MEALY_OUT) begin : g_chk_mealy
            p_mealy_arc_r7: assert property (@(posedge clk) disable iff (rst)
                (credit_q == CR_TEN && (nickel_in || dime_in)) |-> release_o)
                else $error("mealy release missing on completing arc");
        end else begin : g_chk_moore
            p_moore_rise_r6: assert property (@(posedge clk) disable iff (rst)
                $rose(release_o) |-> (credit_q == CR_FULL && $past(credit_q) != CR_FULL))
                else $error("moore release rose outside entry to full");
        end
    endgenerate
endmodule

// File: tb/vend_ctrl_bench.sv
`timescale 1ns/1ps
module vend_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel_in = 1'b0;
    logic dime_in = 1'b0;
    logic rel_moore;
    logic rel_mealy;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    vend_ctrl #(.MEALY_OUT(1'b0), .ONE_HOT(1'b0)) u_vend_ctrl (
        .clk (clk), .rst (rst), .nickel_in (nickel_in), .dime_in (dime_in),
        .release_o (rel_moore)
    );

    vend_ctrl #(.MEALY_OUT(1'b1), .ONE_HOT(1'b1)) u_vend_ctrl_mealy (
        .clk (clk), .rst (rst), .nickel_in (nickel_in), .dime_in (dime_in),
        .release_o (rel_mealy)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: release actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; nickel_in = 1'b0; dime_in = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(rel_moore, 1'b0, "R1 moore after reset");
        check(rel_mealy, 1'b0, "R1 mealy after reset");
    endtask

    function automatic string coin_tag(input int credit, input int kind);
        if (credit >= 15) return "R5";
        case (kind)
            0: return "R4";
            1: return "R2";
            2: return "R3";
            default: return "R8";
        endcase
    endfunction

    task automatic run_seq(input int code);
        int credit = 0;
        do_reset();
        for (int i = 0; i < 5; i++) begin
            int kind = (i < 4) ? ((code >> (2 * i)) & 3) : 0;
            int val = (kind == 0) ? 0 : ((kind == 1) ? 5 : 10);
            logic exp_moore;
            logic exp_mealy;
            string ct;
            @(posedge clk); #1;
            nickel_in = (kind == 1) || (kind == 3);
            dime_in   = (kind == 2) || (kind == 3);
            @(negedge clk);
            exp_moore = (credit >= 15);
            exp_mealy = (credit >= 15) || (val > 0 && credit + val >= 15);
            ct = coin_tag(credit, kind);
            check(rel_moore, exp_moore, {ct, " R6 moore"});
            check(rel_mealy, exp_mealy, {ct, " R7 R9 mealy one-hot"});
            if (credit < 15) credit = (credit + val > 15) ? 15 : credit + val;
        end
        @(posedge clk); #1;
        nickel_in = 1'b0; dime_in = 1'b0;
    endtask

    initial begin
        for (int code = 0; code < 256; code++) run_seq(code);
        do_reset();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
        end
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule